// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes a single asynchronous serial line and turns it into characters of 8 or 9 data bits. The logic runs on the system clock but only advances on a one-cycle tick that the host supplies at sixteen times the baud rate. A falling edge on an idle line starts a character. The line is checked again at the middle of the start bit, and a pulse that has already ended is dropped without any error. Each data bit and the stop bit are decided by a majority vote of three samples taken around the bit centre. A stop bit read as zero marks the character as badly framed.

Finished characters go into a two-entry queue with their framing flag. A third character can arrive on the line while both entries are occupied. The head entry appears on the outputs and a read strobe removes it. If a character completes while both entries are still full, it is thrown away and an overrun flag is raised. The receiver then ignores the line until the continuous-receive enable is dropped. Dropping that enable clears the overrun and keeps the queued characters.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `data_avail` and `overrun` are 0.
- R2: In 8-bit mode (`nine_bit`=0), data bits arrive LSB first. The character appears on `head_data[7:0]` with `head_data[8]`=0, and `head_ferr`=0 when the stop bit is 1.
- R3: In 9-bit mode (`nine_bit`=1), nine data bits are received LSB first and appear on `head_data[8:0]`.
- R4: A stop bit read as 0 still queues the character, with `head_ferr`=1.
- R5: A low pulse that ends before the middle of the start bit (8 ticks after the edge) queues nothing and raises no flag. The receiver then waits for the next falling edge.
- R6: Each bit value is the majority of the samples at ticks 7, 8 and 9 of its bit time. A disturbance that reaches only one of those samples does not change the received value.
- R7: The queue holds two characters and releases them in arrival order. A `rd_pop` pulse removes the head entry. `rd_pop` while the queue is empty has no effect.
- R8: If a character completes while two characters are held and no pop occurs in the same cycle, that character is discarded and `overrun` goes to 1. While `overrun` is 1, no further character is accepted. Driving `cont_en` low clears `overrun` and resets reception, and the queue contents are kept.
- R9: Reception runs only while `port_en`, `cont_en` and `async_sel` are all 1. `data_avail` is 1 only while all three are 1 and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| cont_en | input | 1 | Continuous-receive enable; low clears overrun |
| async_sel | input | 1 | 1 selects asynchronous operation |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| tick16 | input | 1 | One-cycle pulse at 16x baud rate |
| rx_line | input | 1 | Serial input line, idle high |
| rd_pop | input | 1 | Removes the head character |
| head_data | output | 9 | Head character (bit 8 is 0 in 8-bit mode) |
| head_ferr | output | 1 | Framing error flag of the head character |
| data_avail | output | 1 | At least one unread character while enabled |
| overrun | output | 1 | A character was lost to a full queue |

## Verification
The assertions assume that `tick16` is a single-cycle pulse spaced several clocks apart, and that `nine_bit` does not change while a character is on the line. The bench produces the tick as a one-cycle pulse every four clocks and changes the width selection only between frames. Line disturbances in the majority test last three clocks, which is shorter than the tick spacing, so at most one of the three samples can see them.

// File: rtl/serial_rx_pkg.sv
// Shared definitions for the oversampled serial receiver.
// Assumes the oversampling ratio is a power of two of at least 8.
package serial_rx_pkg;
    localparam int OVERSAMPLE = 16;
    localparam int MAX_BITS   = 9;
    localparam int TCNT_W     = $clog2(OVERSAMPLE);
    localparam int BITN_W     = $clog2(MAX_BITS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
// Two-flop synchronizer for the asynchronous line input.
// Resets to the idle-high level so no false edge is seen after reset.
module serial_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    // Move the line into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/serial_rx_framer.sv
// Character framer: finds the start edge, re-checks mid start bit,
// majority-samples data and stop bits, and pulses done with the character.
// Assumes tick is a single-cycle enable and nine is stable during a frame.
module serial_rx_framer
    import serial_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tick,
    input  logic                line,
    input  logic                nine,
    output logic                done,
    output logic [MAX_BITS-1:0] ch,
    output logic                ferr
);
    localparam int MID = OVERSAMPLE / 2;

    rx_state_t           state;
    logic [TCNT_W-1:0]   tcnt;
    logic [BITN_W-1:0]   bitn;
    logic [MAX_BITS-1:0] shreg;
    logic                prev_line, s0, s1, maj;
    logic [BITN_W-1:0]   last_bit;

    assign maj      = (s0 & s1) | (s0 & line) | (s1 & line);
    assign last_bit = nine ? BITN_W'(MAX_BITS - 1) : BITN_W'(MAX_BITS - 2);
    assign ch       = nine ? shreg : {1'b0, shreg[MAX_BITS-1:1]};

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_line <= 1'b1;
        else        prev_line <= line;
    end

    // Frame state machine, advanced on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
            s0    <= 1'b1;
            s1    <= 1'b1;
            done  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    if (prev_line && !line) state <= ST_START;
                end
                ST_START: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TCNT_W'(MID - 1) && line) state <= ST_IDLE;
                    else if (tcnt == TCNT_W'(OVERSAMPLE - 1)) begin
                        state <= ST_DATA;
                        bitn  <= '0;
                    end
                end
                ST_DATA: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TCNT_W'(MID - 1)) s0 <= line;
                    if (tcnt == TCNT_W'(MID))     s1 <= line;
                    if (tcnt == TCNT_W'(MID + 1)) shreg <= {maj, shreg[MAX_BITS-1:1]};
                    if (tcnt == TCNT_W'(OVERSAMPLE - 1)) begin
                        if (bitn == last_bit) state <= ST_STOP;
                        else                  bitn  <= bitn + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TCNT_W'(MID - 1)) s0 <= line;
                    if (tcnt == TCNT_W'(MID))     s1 <= line;
                    if (tcnt == TCNT_W'(MID + 1)) begin
                        ferr  <= ~maj;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the data bit index never passes the configured last bit.
    p_bitn_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |-> bitn <= last_bit);
    // R4: a completed character always comes out of the stop-bit phase.
    p_done_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_STOP);
    // R9: when reception is not allowed the framer sits idle.
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state == ST_IDLE);
endmodule

// File: rtl/serial_rx_queue.sv
// Small first-in first-out store for received characters.
// Push while full and pop while empty are ignored; the owner prevents the former.
module serial_rx_queue #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    // Write the incoming entry into its slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R7: occupancy never exceeds the depth.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7: a pop on an empty queue leaves it empty.
    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/serial_rx_core.sv
// Top of the oversampled serial receiver: synchronizer, framer, two-entry
// queue and overrun lockout. Assumes tick16 is a one-cycle pulse at 16x baud.
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                port_en,
    input  logic                cont_en,
    input  logic                async_sel,
    input  logic                nine_bit,
    input  logic                tick16,
    input  logic                rx_line,
    input  logic                rd_pop,
    output logic [MAX_BITS-1:0] head_data,
    output logic                head_ferr,
    output logic                data_avail,
    output logic                overrun
);
    localparam int QW = MAX_BITS + 1;

    logic                line_s, enabled, run, done, ferr;
    logic [MAX_BITS-1:0] ch;
    logic                q_empty, q_full, q_push, pop_ok;
    logic [QW-1:0]       q_head;

    assign enabled    = port_en && cont_en && async_sel;
    assign run        = enabled && !overrun;
    assign pop_ok     = rd_pop && !q_empty;
    assign q_push     = done && (!q_full || pop_ok);
    assign head_data  = q_head[MAX_BITS-1:0];
    assign head_ferr  = q_head[MAX_BITS];
    assign data_avail = enabled && !q_empty;

    serial_rx_sync u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
    );

    serial_rx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick16), .line(line_s),
        .nine(nine_bit), .done(done), .ch(ch), .ferr(ferr)
    );

    serial_rx_queue #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din({ferr, ch}),
        .pop(rd_pop), .dout(q_head), .empty(q_empty), .full(q_full)
    );

    // Raise overrun on a lost character; clear it when continuous receive drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !cont_en)             overrun <= 1'b0;
        else if (done && q_full && !pop_ok) overrun <= 1'b1;
    end

    // R8: a character arriving at a full queue without a pop sets overrun.
    p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q_full && !rd_pop && cont_en) |=> overrun);
    // R8: no character completes while the receiver is locked out.
    p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !done);
    // R8: overrun cannot survive a low continuous-receive enable.
    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_en |=> !overrun);
endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
    localparam int CLK_PER_TICK = 4;
    localparam int BIT_CLKS     = 16 * CLK_PER_TICK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, cont_en = 1'b0, async_sel = 1'b0, nine_bit = 1'b0;
    logic       tick16 = 1'b0, rx_line = 1'b1, rd_pop = 1'b0;
    logic [8:0] head_data;
    logic       head_ferr, data_avail, overrun;
    int         n_checks = 0, n_fail = 0;

    serial_rx_core uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
        .async_sel(async_sel), .nine_bit(nine_bit), .tick16(tick16),
        .rx_line(rx_line), .rd_pop(rd_pop), .head_data(head_data),
        .head_ferr(head_ferr), .data_avail(data_avail), .overrun(overrun)
    );

    always #5 clk = ~clk;

    // Oversampling tick: one clock high every CLK_PER_TICK clocks.
    initial begin
        forever begin
            repeat (CLK_PER_TICK - 1) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clks);
        rx_line = v;
        repeat (clks) @(negedge clk);
    endtask

    // Send one frame; gbit >= 0 flips that data bit for 3 clocks at its centre.
    task automatic send(input logic [8:0] d, input bit nine, input logic stopv, input int gbit);
        int nb = nine ? 9 : 8;
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < nb; i++) begin
            if (i == gbit) begin
                hold(d[i], BIT_CLKS / 2 - 1);
                hold(~d[i], 3);
                hold(d[i], BIT_CLKS / 2 - 2);
            end else hold(d[i], BIT_CLKS);
        end
        hold(stopv, BIT_CLKS);
        hold(1'b1, 8);
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(data_avail == 0, "R1 avail after reset", data_avail, 0);
        check(overrun == 0, "R1 overrun after reset", overrun, 0);
    endtask

    task automatic t_eight();
        nine_bit = 0;
        send(9'h0A5, 0, 1'b1, -1);
        check(data_avail == 1, "R2 avail", data_avail, 1);
        check(head_data == 9'h0A5, "R2 data", head_data, 9'h0A5);
        check(head_ferr == 0, "R2 ferr", head_ferr, 0);
        pop();
        check(data_avail == 0, "R7 empty after pop", data_avail, 0);
    endtask

    task automatic t_nine();
        nine_bit = 1;
        send(9'h1C3, 1, 1'b1, -1);
        check(head_data == 9'h1C3, "R3 nine-bit data", head_data, 9'h1C3);
        pop();
        nine_bit = 0;
    endtask

    task automatic t_frame_err();
        send(9'h03C, 0, 1'b0, -1);
        hold(1'b1, BIT_CLKS);
        check(data_avail == 1, "R4 char kept", data_avail, 1);
        check(head_ferr == 1, "R4 ferr set", head_ferr, 1);
        check(head_data == 9'h03C, "R4 data", head_data, 9'h03C);
        pop();
    endtask

    task automatic t_abort();
        hold(1'b0, 5 * CLK_PER_TICK);
        hold(1'b1, 12 * BIT_CLKS);
        check(data_avail == 0, "R5 nothing queued", data_avail, 0);
        check(overrun == 0, "R5 no flag", overrun, 0);
        send(9'h05A, 0, 1'b1, -1);
        check(head_data == 9'h05A, "R5 next frame ok", head_data, 9'h05A);
        pop();
    endtask

    task automatic t_majority();
        send(9'h0F0, 0, 1'b1, 2);
        check(head_data == 9'h0F0, "R6 glitch bit2", head_data, 9'h0F0);
        pop();
        send(9'h0F0, 0, 1'b1, 5);
        check(head_data == 9'h0F0, "R6 glitch bit5", head_data, 9'h0F0);
        pop();
    endtask

    task automatic t_queue();
        pop();
        check(data_avail == 0, "R7 pop empty", data_avail, 0);
        send(9'h011, 0, 1'b1, -1);
        send(9'h022, 0, 1'b1, -1);
        check(head_data == 9'h011, "R7 first out", head_data, 9'h011);
        check(overrun == 0, "R7 two fit", overrun, 0);
        pop();
        check(head_data == 9'h022, "R7 second out", head_data, 9'h022);
        pop();
        check(data_avail == 0, "R7 drained", data_avail, 0);
    endtask

    task automatic t_overrun();
        send(9'h0A1, 0, 1'b1, -1);
        send(9'h0B2, 0, 1'b1, -1);
        send(9'h0C3, 0, 1'b1, -1);
        check(overrun == 1, "R8 overrun set", overrun, 1);
        check(head_data == 9'h0A1, "R8 head kept", head_data, 9'h0A1);
        pop();
        send(9'h0D4, 0, 1'b1, -1);
        check(head_data == 9'h0B2, "R8 lockout head", head_data, 9'h0B2);
        pop();
        check(data_avail == 0, "R8 locked char dropped", data_avail, 0);
        send(9'h0E5, 0, 1'b1, -1);
        cont_en = 0;
        @(negedge clk); @(negedge clk);
        check(overrun == 0, "R8 overrun cleared", overrun, 0);
        cont_en = 1;
        @(negedge clk);
        check(data_avail == 0, "R8 still empty", data_avail, 0);
        send(9'h0F6, 0, 1'b1, -1);
        check(head_data == 9'h0F6, "R8 receive resumes", head_data, 9'h0F6);
        send(9'h077, 0, 1'b1, -1);
        send(9'h088, 0, 1'b1, -1);
        cont_en = 0;
        @(negedge clk); @(negedge clk);
        cont_en = 1;
        @(negedge clk);
        check(data_avail == 1, "R8 queue kept", data_avail, 1);
        check(head_data == 9'h0F6, "R8 queue head kept", head_data, 9'h0F6);
        pop();
        pop();
    endtask

    task automatic t_enables();
        port_en = 0;
        send(9'h033, 0, 1'b1, -1);
        port_en = 1;
        @(negedge clk);
        check(data_avail == 0, "R9 port_en off ignored", data_avail, 0);
        async_sel = 0;
        send(9'h044, 0, 1'b1, -1);
        async_sel = 1;
        @(negedge clk);
        check(data_avail == 0, "R9 sync mode ignored", data_avail, 0);
        send(9'h055, 0, 1'b1, -1);
        port_en = 0;
        @(negedge clk);
        check(data_avail == 0, "R9 avail gated", data_avail, 0);
        port_en = 1;
        @(negedge clk);
        check(data_avail == 1, "R9 avail returns", data_avail, 1);
        pop();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        port_en = 1; cont_en = 1; async_sel = 1;
        repeat (4) @(negedge clk);
        t_eight();
        t_nine();
        t_frame_err();
        t_abort();
        t_majority();
        t_queue();
        t_overrun();
        t_enables();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule